// File: doc/BRIEF.md
# I2C Slave Bus Status Tracker

This block sits on the slave side of a two-wire bus and keeps a set of status flags for host software. It watches the clock and data lines and spots the bus START and STOP conditions. It decodes the address that follows a START in either 7-bit or 10-bit form, acknowledges a match by pulling data low, and then receives or sends bytes. It reports which bus condition came last, whether the most recent byte was an address or data, the direction bit of the latest address match, a request to reload the address register during 10-bit addressing, and a buffer-full flag that serves both directions.

The bus lines come in raw and pass through a synchronizer chain inside the block. The block finds line edges by sampling on the system clock, so that clock must run many times faster than SCL. The host side is a set of single-cycle strobes: one reads the receive buffer, one writes the transmit buffer, and one reports that the own-address register has been rewritten.

Top module: `i2cs_status_tracker`

## Requirements
- R1: After reset, every status flag is 0, rx_data is 0 and sda_drive_low is 0.
- R2: A START (SDA falling while SCL is high) sets st_start and clears st_stop. A STOP (SDA rising while SCL is high) sets st_stop and clears st_start. The two flags are never both 1.
- R3: While enable is 0, st_start and st_stop are held at 0. The block ignores bus activity and never pulls SDA low, including any START seen while it is disabled.
- R4: In 7-bit mode (ten_bit_mode=0), the first byte after a START matches when its bits 7:1 equal own_addr[6:0]. On a match the block pulls SDA low for the ninth clock, clears st_data and loads st_rw from bit 0 (1 means read). On a mismatch the block gives no acknowledge and changes no flag or buffer until the next START.
- R5: st_rw is cleared by a START, by a STOP, and at the end of the acknowledge slot of the first data byte after the address.
- R6: When a written data byte completes with st_buf_full at 0, the byte appears on rx_data, st_buf_full and st_data become 1, and the byte is acknowledged. A host_rd_strobe pulse clears st_buf_full.
- R7: When a written data byte completes while st_buf_full is 1, the byte is not acknowledged and rx_data keeps its old value.
- R8: A host_wr_strobe pulse loads host_wdata and sets st_buf_full. In a read, the block puts that byte on SDA MSB first, starting after each acknowledge slot. st_buf_full falls to 0 and st_data rises to 1 once the eighth bit has been clocked out.
- R9: If the master does not acknowledge a byte the block has sent, the block releases SDA and sends nothing more until the next START.
- R10: In 10-bit mode, a first byte of 11110, own_addr[9:8] and write bit 0, followed by a second byte equal to own_addr[7:0], is acknowledged byte by byte. Each acknowledged address byte sets st_upd_addr, and a host_addr_wr_strobe pulse clears it. A first byte carrying different high bits gets no acknowledge.
- R11: After a full 10-bit write match, a repeated START followed by the first byte with read bit 1 is acknowledged, sets st_rw to 1 and starts a transmit. The match is forgotten at STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Module enable |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| own_addr | input | 10 | Own slave address (7-bit mode uses bits 6:0) |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| sda_drive_low | output | 1 | 1 pulls SDA low (open drain) |
| host_rd_strobe | input | 1 | Host has read the receive buffer |
| host_wr_strobe | input | 1 | Host writes the transmit buffer |
| host_wdata | input | 8 | Transmit byte written by the host |
| host_addr_wr_strobe | input | 1 | Host has rewritten the own-address register |
| rx_data | output | 8 | Last accepted received byte |
| st_start | output | 1 | START was the last bus condition |
| st_stop | output | 1 | STOP was the last bus condition |
| st_data | output | 1 | 1: last byte was data, 0: address |
| st_rw | output | 1 | Direction bit of the latest address match |
| st_upd_addr | output | 1 | Host must reload the address register |
| st_buf_full | output | 1 | Receive byte waiting or transmit byte pending |

## Verification
The block sees a line change one cycle after the last synchronizer stage. The edge detector fires in the following cycle, and the engine or status registers update one cycle later. Every flag is therefore due about four system clocks after the line changes, and SDA pull-down about four clocks after the SCL falling edge that ends the byte or slot. The bench holds each bus phase for eight clocks and reads flags only after a full phase has passed. It samples SDA while SCL is high, at the end of a phase, so each result is read well after it is due and before the next line change. Host strobes last one cycle and are checked two cycles later.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W   = 8;
    localparam int OWN_W    = 10;
    localparam int CNT_W    = $clog2(BYTE_W + 2);
    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR2,
        ST_RX,
        ST_TX
    } eng_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_evt_t;

    typedef struct packed {
        logic              addr_ack;
        logic              rw;
        logic              ua_req;
        logic              rx_take;
        logic [BYTE_W-1:0] rx_byte;
        logic              tx_done;
        logic              slot_end;
    } eng_evt_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic data;
        logic rw;
        logic upd;
        logic full;
    } status_t;

    function automatic logic hit7(input logic [BYTE_W-1:0] b,
                                  input logic [OWN_W-1:0]  own);
        return b[7:1] == own[6:0];
    endfunction

    function automatic logic hit10_hi(input logic [BYTE_W-1:0] b,
                                      input logic [OWN_W-1:0]  own);
        return (b[7:3] == TEN_PREFIX) && (b[2:1] == own[9:8]);
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_raw,
    input  logic     sda_raw,
    output logic     sda_s,
    output bus_evt_t ev
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;

    assign raw = {scl_raw, sda_raw};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain   <= '1;
                prev[g] <= 1'b1;
            end else begin
                chain   <= {chain[STAGES-2:0], raw[g]};
                prev[g] <= chain[STAGES-1];
            end
        end
        assign synced[g] = chain[STAGES-1];
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = synced[1];
    assign scl_old = prev[1];
    assign sda_now = synced[0];
    assign sda_old = prev[0];
    assign sda_s   = sda_now;

    always_comb begin
        ev.start    = scl_now && scl_old && sda_old && !sda_now;
        ev.stop     = scl_now && scl_old && !sda_old && sda_now;
        ev.scl_rise = scl_now && !scl_old;
        ev.scl_fall = !scl_now && scl_old;
    end

    // R2: a START and a STOP can never be reported in the same cycle
    a_r2_evt_excl: assert property (@(posedge clk) disable iff (rst)
        !(ev.start && ev.stop));

endmodule

// File: rtl/i2cs_byte_engine.sv
module i2cs_byte_engine
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ten_bit,
    input  logic [OWN_W-1:0]  own_addr,
    input  bus_evt_t          ev,
    input  logic              sda_s,
    input  logic              buf_full,
    input  logic [BYTE_W-1:0] tx_buf,
    output logic              sda_low,
    output eng_evt_t          eo
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W + 1);

    eng_state_e        st;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txsh;
    logic              ack_drv;
    logic              tx_active;
    logic              ten_ok;

    logic live, byte_done, slot_done, accept;

    always_comb begin
        live      = en && !ev.start && !ev.stop && (st != ST_IDLE);
        byte_done = live && ev.scl_fall && (bitcnt == LAST_BIT);
        slot_done = live && ev.scl_fall && (bitcnt == ACK_SLOT);
        case (st)
            ST_ADDR:  accept = ten_bit ? (hit10_hi(shreg, own_addr) && (!shreg[0] || ten_ok))
                                       : hit7(shreg, own_addr);
            ST_ADDR2: accept = (shreg == own_addr[7:0]);
            ST_RX:    accept = !buf_full;
            default:  accept = 1'b0;
        endcase
        eo.addr_ack = byte_done && ((st == ST_ADDR) || (st == ST_ADDR2)) && accept;
        eo.rw       = (st == ST_ADDR) && shreg[0];
        eo.ua_req   = ten_bit;
        eo.rx_take  = byte_done && (st == ST_RX) && accept;
        eo.rx_byte  = shreg;
        eo.tx_done  = byte_done && (st == ST_TX);
        eo.slot_end = slot_done;
        sda_low     = ack_drv || (tx_active && !txsh[BYTE_W-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txsh      <= '1;
            ack_drv   <= 1'b0;
            tx_active <= 1'b0;
            ten_ok    <= 1'b0;
        end else if (!en) begin
            st        <= ST_IDLE;
            bitcnt    <= '0;
            ack_drv   <= 1'b0;
            tx_active <= 1'b0;
            ten_ok    <= 1'b0;
        end else if (ev.start) begin
            st        <= ST_ADDR;
            bitcnt    <= '0;
            ack_drv   <= 1'b0;
            tx_active <= 1'b0;
        end else if (ev.stop) begin
            st        <= ST_IDLE;
            bitcnt    <= '0;
            ack_drv   <= 1'b0;
            tx_active <= 1'b0;
            ten_ok    <= 1'b0;
        end else if (st != ST_IDLE) begin
            if (ev.scl_rise) begin
                if (bitcnt < LAST_BIT)
                    shreg <= {shreg[BYTE_W-2:0], sda_s};
                if ((bitcnt == LAST_BIT) && (st == ST_TX) && sda_s)
                    st <= ST_IDLE;
                if (bitcnt <= LAST_BIT)
                    bitcnt <= bitcnt + 1'b1;
            end
            if (ev.scl_fall) begin
                if (tx_active && (bitcnt != '0) && (bitcnt < LAST_BIT))
                    txsh <= {txsh[BYTE_W-2:0], 1'b1};
                if (bitcnt == LAST_BIT) begin
                    tx_active <= 1'b0;
                    case (st)
                        ST_ADDR: begin
                            if (accept) begin
                                ack_drv <= 1'b1;
                                if (ten_bit && !shreg[0]) st <= ST_ADDR2;
                                else if (shreg[0])        st <= ST_TX;
                                else                      st <= ST_RX;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                        ST_ADDR2: begin
                            if (accept) begin
                                ack_drv <= 1'b1;
                                ten_ok  <= 1'b1;
                                st      <= ST_RX;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                        ST_RX:   ack_drv <= accept;
                        default: ;
                    endcase
                end
                if (bitcnt == ACK_SLOT) begin
                    ack_drv <= 1'b0;
                    bitcnt  <= '0;
                    if (st == ST_TX) begin
                        txsh      <= tx_buf;
                        tx_active <= 1'b1;
                    end
                end
            end
        end
    end

    // R9: an idle engine never holds the data line low
    a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_low);
    // R4: an accepted address is acknowledged from the next cycle
    a_r4_ack_follows_match: assert property (@(posedge clk) disable iff (rst)
        eo.addr_ack |=> sda_low);
    // R3: a disabled block lets go of the line
    a_r3_disabled_release: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sda_low);

endmodule

// File: rtl/i2cs_status_regs.sv
module i2cs_status_regs
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  eng_evt_t          eo,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              host_addr_wr,
    output status_t           stat,
    output logic [BYTE_W-1:0] rx_buf,
    output logic [BYTE_W-1:0] tx_buf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat   <= '0;
            rx_buf <= '0;
            tx_buf <= '1;
        end else begin
            if (!en) begin
                stat.start <= 1'b0;
                stat.stop  <= 1'b0;
            end else if (bus_start) begin
                stat.start <= 1'b1;
                stat.stop  <= 1'b0;
                stat.rw    <= 1'b0;
            end else if (bus_stop) begin
                stat.stop  <= 1'b1;
                stat.start <= 1'b0;
                stat.rw    <= 1'b0;
            end

            if (eo.slot_end && stat.data)
                stat.rw <= 1'b0;

            if (host_addr_wr)
                stat.upd <= 1'b0;

            if (eo.addr_ack) begin
                stat.data <= 1'b0;
                stat.rw   <= eo.rw;
                if (eo.ua_req)
                    stat.upd <= 1'b1;
            end

            if (host_rd)
                stat.full <= 1'b0;
            if (eo.tx_done) begin
                stat.full <= 1'b0;
                stat.data <= 1'b1;
            end
            if (host_wr) begin
                stat.full <= 1'b1;
                tx_buf    <= host_wdata;
            end
            if (eo.rx_take) begin
                stat.full <= 1'b1;
                stat.data <= 1'b1;
                rx_buf    <= eo.rx_byte;
            end
        end
    end

    // R2: START and STOP flags are mutually exclusive
    a_r2_start_stop_excl: assert property (@(posedge clk) disable iff (rst)
        !(stat.start && stat.stop));
    // R3: disable clears both condition flags
    a_r3_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!stat.start && !stat.stop));
    // R5: a START drops the direction bit
    a_r5_rw_clear_on_start: assert property (@(posedge clk) disable iff (rst)
        (en && bus_start) |=> !stat.rw);
    // R6: an accepted byte leaves the buffer marked full
    a_r6_full_after_rx: assert property (@(posedge clk) disable iff (rst)
        eo.rx_take |=> stat.full);
    // R7: a full receive buffer is never overwritten
    a_r7_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        stat.full |=> $stable(rx_buf));

endmodule

// File: rtl/i2cs_status_tracker.sv
module i2cs_status_tracker
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        ten_bit_mode,
    input  logic [9:0]  own_addr,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_drive_low,
    input  logic        host_rd_strobe,
    input  logic        host_wr_strobe,
    input  logic [7:0]  host_wdata,
    input  logic        host_addr_wr_strobe,
    output logic [7:0]  rx_data,
    output logic        st_start,
    output logic        st_stop,
    output logic        st_data,
    output logic        st_rw,
    output logic        st_upd_addr,
    output logic        st_buf_full
);
    bus_evt_t          bev;
    eng_evt_t          eev;
    status_t           stat;
    logic              sda_s;
    logic [BYTE_W-1:0] tx_buf;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .sda_s   (sda_s),
        .ev      (bev)
    );

    i2cs_byte_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .en       (enable),
        .ten_bit  (ten_bit_mode),
        .own_addr (own_addr),
        .ev       (bev),
        .sda_s    (sda_s),
        .buf_full (stat.full),
        .tx_buf   (tx_buf),
        .sda_low  (sda_drive_low),
        .eo       (eev)
    );

    i2cs_status_regs u_stat (
        .clk          (clk),
        .rst          (rst),
        .en           (enable),
        .bus_start    (bev.start),
        .bus_stop     (bev.stop),
        .eo           (eev),
        .host_rd      (host_rd_strobe),
        .host_wr      (host_wr_strobe),
        .host_wdata   (host_wdata),
        .host_addr_wr (host_addr_wr_strobe),
        .stat         (stat),
        .rx_buf       (rx_data),
        .tx_buf       (tx_buf)
    );

    assign st_start    = stat.start;
    assign st_stop     = stat.stop;
    assign st_data     = stat.data;
    assign st_rw       = stat.rw;
    assign st_upd_addr = stat.upd;
    assign st_buf_full = stat.full;

endmodule

// File: tb/i2cs_status_tracker_tb.sv
module i2cs_status_tracker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PHASE      = 8;
    localparam int WDOG       = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       ten_bit_mode = 1'b0;
    logic [9:0] own_addr = 10'h02A;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_drive_low;
    logic       host_rd_strobe = 1'b0;
    logic       host_wr_strobe = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       host_addr_wr_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       st_start, st_stop, st_data, st_rw, st_upd_addr, st_buf_full;
    logic       sda_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = m_sda & ~sda_drive_low;

    i2cs_status_tracker dut_i (
        .clk                 (clk),
        .rst                 (rst),
        .enable              (enable),
        .ten_bit_mode        (ten_bit_mode),
        .own_addr            (own_addr),
        .scl_in              (m_scl),
        .sda_in              (sda_line),
        .sda_drive_low       (sda_drive_low),
        .host_rd_strobe      (host_rd_strobe),
        .host_wr_strobe      (host_wr_strobe),
        .host_wdata          (host_wdata),
        .host_addr_wr_strobe (host_addr_wr_strobe),
        .rx_data             (rx_data),
        .st_start            (st_start),
        .st_stop             (st_stop),
        .st_data             (st_data),
        .st_rw               (st_rw),
        .st_upd_addr         (st_upd_addr),
        .st_buf_full         (st_buf_full)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (PHASE) @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk) host_rd_strobe = 1'b1;
        @(negedge clk) host_rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_addr_wr();
        @(negedge clk) host_addr_wr_strobe = 1'b1;
        @(negedge clk) host_addr_wr_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_load(input logic [7:0] b);
        @(negedge clk) begin host_wr_strobe = 1'b1; host_wdata = b; end
        @(negedge clk) host_wr_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq();
            m_scl = 1'b1; wq();
            m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        acked = ~sda_line;
        m_scl = 1'b0; wq();
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl = 1'b1; wq();
            b[i] = sda_line;
            m_scl = 1'b0;
        end
        wq();
        m_sda = nack; wq();
        m_scl = 1'b1; wq();
        m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 start", st_start, 0);
        chk("R1 stop", st_stop, 0);
        chk("R1 data", st_data, 0);
        chk("R1 rw", st_rw, 0);
        chk("R1 upd", st_upd_addr, 0);
        chk("R1 full", st_buf_full, 0);
        chk("R1 rx_data", rx_data, 8'h00);
        chk("R1 sda", sda_drive_low, 0);
    endtask

    task automatic t_write7();
        logic a;
        bus_start();
        chk("R2 start set", st_start, 1);
        chk("R2 stop clr", st_stop, 0);
        send_byte(8'h54, a);
        chk("R4 ack", a, 1);
        chk("R4 data=addr", st_data, 0);
        chk("R4 rw write", st_rw, 0);
        send_byte(8'hA5, a);
        chk("R6 ack", a, 1);
        chk("R6 rx_data", rx_data, 8'hA5);
        chk("R6 full", st_buf_full, 1);
        chk("R6 data", st_data, 1);
        pulse_rd();
        chk("R6 rd clears full", st_buf_full, 0);
        bus_stop();
        chk("R2 stop set", st_stop, 1);
        chk("R2 start clr", st_start, 0);
    endtask

    task automatic t_read7();
        logic a;
        logic [7:0] b;
        host_load(8'hC3);
        chk("R8 wr sets full", st_buf_full, 1);
        bus_start();
        send_byte(8'h55, a);
        chk("R4 read ack", a, 1);
        chk("R4 rw read", st_rw, 1);
        chk("R5 rw held after addr slot", st_rw, 1);
        read_byte(1'b0, b);
        chk("R8 byte out", b, 8'hC3);
        chk("R8 full cleared", st_buf_full, 0);
        chk("R8 data", st_data, 1);
        chk("R5 rw cleared after data slot", st_rw, 0);
        read_byte(1'b1, b);
        chk("R8 second byte", b, 8'hC3);
        read_byte(1'b1, b);
        chk("R9 silent after nack", b, 8'hFF);
        chk("R9 released", sda_drive_low, 0);
        bus_stop();
    endtask

    task automatic t_mismatch7();
        logic a;
        bus_start();
        send_byte(8'h40, a);
        chk("R4 no ack on mismatch", a, 0);
        send_byte(8'h11, a);
        chk("R4 ignored byte no ack", a, 0);
        chk("R4 rx unchanged", rx_data, 8'hA5);
        chk("R4 full unchanged", st_buf_full, 0);
        chk("R4 data unchanged", st_data, 1);
        bus_stop();
    endtask

    task automatic t_overflow();
        logic a;
        bus_start();
        send_byte(8'h54, a);
        send_byte(8'h11, a);
        chk("R6 rx 11", rx_data, 8'h11);
        send_byte(8'h22, a);
        chk("R7 no ack when full", a, 0);
        chk("R7 rx kept", rx_data, 8'h11);
        chk("R7 full kept", st_buf_full, 1);
        pulse_rd();
        bus_stop();
    endtask

    task automatic t_disable();
        logic a;
        @(negedge clk) enable = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 stop cleared", st_stop, 0);
        chk("R3 start cleared", st_start, 0);
        bus_start();
        chk("R3 start ignored", st_start, 0);
        send_byte(8'h54, a);
        chk("R3 no ack when disabled", a, 0);
        bus_stop();
        chk("R3 stop ignored", st_stop, 0);
        @(negedge clk) enable = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_ten_bit();
        logic a;
        logic [7:0] b;
        @(negedge clk) begin ten_bit_mode = 1'b1; own_addr = 10'h2A5; end
        bus_start();
        send_byte(8'hF2, a);
        chk("R10 wrong high bits no ack", a, 0);
        chk("R10 upd stays 0", st_upd_addr, 0);
        bus_stop();
        bus_start();
        send_byte(8'hF4, a);
        chk("R10 first byte ack", a, 1);
        chk("R10 upd after first", st_upd_addr, 1);
        chk("R10 data=addr", st_data, 0);
        pulse_addr_wr();
        chk("R10 upd cleared", st_upd_addr, 0);
        send_byte(8'hA5, a);
        chk("R10 second byte ack", a, 1);
        chk("R10 upd after second", st_upd_addr, 1);
        pulse_addr_wr();
        send_byte(8'h3C, a);
        chk("R10 data ack", a, 1);
        chk("R10 rx data", rx_data, 8'h3C);
        pulse_rd();
        host_load(8'h96);
        bus_start();
        chk("R11 repeated start", st_start, 1);
        send_byte(8'hF5, a);
        chk("R11 read header ack", a, 1);
        chk("R11 rw read", st_rw, 1);
        chk("R11 upd set", st_upd_addr, 1);
        read_byte(1'b1, b);
        chk("R11 byte out", b, 8'h96);
        bus_stop();
        pulse_addr_wr();
        bus_start();
        send_byte(8'hF5, a);
        chk("R11 match forgotten after stop", a, 0);
        bus_stop();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        enable = 1'b1;
        repeat (3) @(negedge clk);
        t_write7();
        t_read7();
        t_mismatch7();
        t_overflow();
        t_disable();
        t_ten_bit();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule